// File: doc/BRIEF.md
# Load-Current-Aware Dead-Time Compensator

This block sits between a PWM generator and the two gate drivers of one half-bridge inverter leg. It receives the ideal on/off command for the upper switch, the ideal command for the lower switch (normally its complement) and a bit that gives the sign of the load current. It returns the two gate commands with a blanking gap between the turn-off of one switch and the turn-on of the other, so the leg is never shorted.

The gap is not split evenly between the two switches. When current flows out of the leg (positive), the output voltage follows the upper switch. The upper gate then repeats the ideal pattern exactly, only shifted by a fixed pipeline latency. The lower gate turns off early and turns on late. When the current is negative the roles swap. The edges of the resulting output voltage therefore line up with the ideal pattern. This removes the loss of fundamental amplitude and the low-order distortion that a symmetric dead time causes. To let an edge be moved earlier without looking ahead, both ideal streams pass through a delay line of D clocks. D is a dead-time count from 1 to 255 that is loaded while the leg is disabled.

Top module: `dtc_leg`

## Requirements
- R1: During and directly after synchronous reset both gate outputs are low. Before the first enabled cycle the role is "upper tracks" and the dead count is 1.
- R2: While `en` is low, both gates are low at the next clock edge and the delay history is cleared. The dead count and the current-sign role are loaded in these cycles.
- R3: `gate_up` and `gate_dn` are never high in the same cycle.
- R4: With role "upper tracks" (`cur_dir` = 1), `gate_up` after edge n+D+1 equals the ideal upper value sampled at edge n. The ideal upper value is `ideal_up` high and `ideal_dn` low.
- R5: With role "upper tracks", `gate_dn` after edge n+1 is high only if the ideal lower value (`ideal_dn` high and `ideal_up` low) was high at samples n, n-D and n-2D. So the lower switch turns off one edge after its ideal fall and turns on 2D+1 edges after its ideal rise.
- R6: With role "lower tracks" (`cur_dir` = 0), the rules of R4 and R5 apply with the upper and lower switches exchanged.
- R7: `cur_dir` passes through a two-flop synchronizer. The role takes the synchronized value only at an edge where the ideal upper value is sampled high after being sampled low on the previous enabled edge, or at an edge where `en` is low. A change in the middle of a pulse has no effect until the next rising ideal upper edge.
- R8: `dead_cyc` is taken into the dead count only at edges where `en` is low. A value of 0 is taken as 1. Changes while enabled have no effect on the gaps.
- R9: An ideal sample with both inputs high or both low counts as "off" for both switches.
- R10: For complementary ideal inputs with every pulse longer than 2D, the gap between one gate falling and the other rising is exactly D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Leg enable; low forces both gates off and loads settings |
| ideal_up | input | 1 | Ideal command for the upper switch |
| ideal_dn | input | 1 | Ideal command for the lower switch |
| cur_dir | input | 1 | Load-current sign, 1 = positive, asynchronous |
| dead_cyc | input | DW | Dead-time count in clocks |
| gate_up | output | 1 | Registered upper gate command |
| gate_dn | output | 1 | Registered lower gate command |

## Verification
A cycle model in the bench applies the requirement rules at each rising edge. The tracking gate is due D+1 edges after its ideal sample. The early turn-off is due one edge after. The late turn-on is due 2D+1 edges after the rise. A polarity change is adopted only at the first rising ideal upper edge at least two edges after it arrives. Outputs are compared on the falling edge, away from the active edge, so every result is read after the edge that makes it. Directed phases measure the gap between one gate falling and the other rising, in falling-edge counts, at D = 1, a mid value and 255.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic {
    ROLE_LOW_TRACKS = 1'b0,
    ROLE_UP_TRACKS  = 1'b1
  } role_e;

  function automatic logic [7:0] clamp_dead(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction
endpackage

// File: rtl/dtc_sync2.sv
module dtc_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dtc_tap_line.sv
module dtc_tap_line #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          tap0,
  output logic          tap_d,
  output logic          tap_2d
);
  localparam int MAXD = (1 << DW) - 1;
  localparam int LEN  = 2 * MAXD + 1;
  localparam int AW   = $clog2(LEN);

  logic [LEN-1:0] line;
  logic [AW-1:0]  idx_d;
  logic [AW-1:0]  idx_2d;

  assign idx_d  = AW'(dly);
  assign idx_2d = AW'({dly, 1'b0});

  always_ff @(posedge clk) begin
    if (rst || clr) line <= '0;
    else            line <= {line[LEN-2:0], din};
  end

  assign tap0   = line[0];
  assign tap_d  = line[idx_d];
  assign tap_2d = line[idx_2d];
endmodule

// File: rtl/dtc_gate_shaper.sv
module dtc_gate_shaper (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic track,
  input  logic t0,
  input  logic td,
  input  logic t2d,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (rst || !en)  gate <= 1'b0;
    else if (track)  gate <= td;
    else             gate <= t0 & td & t2d;
  end

  // R2
  disabled_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate);
endmodule

// File: rtl/dtc_leg.sv
module dtc_leg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ideal_up,
  input  logic          ideal_dn,
  input  logic          cur_dir,
  input  logic [DW-1:0] dead_cyc,
  output logic          gate_up,
  output logic          gate_dn
);
  import dtc_pkg::*;

  localparam int NSW = 2;

  logic          dir_s;
  role_e         role_q;
  logic [DW-1:0] dead_q;
  logic [NSW-1:0] want;
  logic [NSW-1:0] t0, td, t2d, trk, gate;
  logic          up_rise;
  logic          role_load;

  // R9: only an unambiguous sample counts as "on"
  assign want[0] = ideal_up & ~ideal_dn;
  assign want[1] = ideal_dn & ~ideal_up;

  dtc_sync2 u_sync (.clk(clk), .rst(rst), .d(cur_dir), .q(dir_s));

  assign up_rise   = want[0] & ~t0[0];
  assign role_load = !en || up_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      role_q <= ROLE_UP_TRACKS;
      dead_q <= DW'(1);
    end else begin
      if (role_load) role_q <= role_e'(dir_s);
      if (!en)       dead_q <= (dead_cyc == '0) ? DW'(1) : dead_cyc;
    end
  end

  assign trk[0] = (role_q == ROLE_UP_TRACKS);
  assign trk[1] = (role_q == ROLE_LOW_TRACKS);

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    dtc_tap_line #(.DW(DW)) u_line (
      .clk(clk), .rst(rst), .clr(!en), .din(want[g]), .dly(dead_q),
      .tap0(t0[g]), .tap_d(td[g]), .tap_2d(t2d[g])
    );
    dtc_gate_shaper u_shape (
      .clk(clk), .rst(rst), .en(en), .track(trk[g]),
      .t0(t0[g]), .td(td[g]), .t2d(t2d[g]), .gate(gate[g])
    );
  end

  assign gate_up = gate[0];
  assign gate_dn = gate[1];

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_up && gate_dn));

  // R8
  dead_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(dead_q));

  // R7
  role_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !up_rise) |=> $stable(role_q));

  // R1
  reset_off_chk: assert property (@(posedge clk)
    rst |=> (!gate_up && !gate_dn));
endmodule

// File: tb/test_dtc_leg.sv
module test_dtc_leg;
  localparam int DW   = 8;
  localparam int MAXD = 255;
  localparam int LEN  = 2 * MAXD + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic ideal_up = 1'b0;
  logic ideal_dn = 1'b0;
  logic cur_dir = 1'b1;
  logic [DW-1:0] dead_cyc = 8'd1;
  logic gate_up, gate_dn;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtc_leg #(.DW(DW)) i_dtc_leg (
    .clk(clk), .rst(rst), .en(en), .ideal_up(ideal_up), .ideal_dn(ideal_dn),
    .cur_dir(cur_dir), .dead_cyc(dead_cyc), .gate_up(gate_up), .gate_dn(gate_dn)
  );

  // ---------------- reference model from the requirements ----------------
  logic [LEN-1:0] mh = '0, ml = '0;
  bit m_s1 = 0, m_s2 = 0, m_role = 1, m_ghi = 0, m_glo = 0, m_dis = 1;
  int m_dq = 1;

  always @(posedge clk) begin
    bit ah, al, nh, nl, rise;
    ah = ideal_up & ~ideal_dn;
    al = ideal_dn & ~ideal_up;
    if (rst) begin
      mh = '0; ml = '0; m_s1 = 0; m_s2 = 0; m_role = 1; m_dq = 1;
      m_ghi = 0; m_glo = 0; m_dis = 1;
    end else if (!en) begin
      m_ghi = 0; m_glo = 0; mh = '0; ml = '0; m_dis = 1;
      m_dq = (dead_cyc == 0) ? 1 : int'(dead_cyc);
      m_role = m_s2;
      m_s2 = m_s1; m_s1 = cur_dir;
    end else begin
      m_dis = 0;
      nh = m_role ? mh[m_dq] : (mh[0] & mh[m_dq] & mh[2*m_dq]);
      nl = m_role ? (ml[0] & ml[m_dq] & ml[2*m_dq]) : ml[m_dq];
      rise = ah & ~mh[0];
      if (rise) m_role = m_s2;
      mh = {mh[LEN-2:0], ah};
      ml = {ml[LEN-2:0], al};
      m_ghi = nh; m_glo = nl;
      m_s2 = m_s1; m_s1 = cur_dir;
    end
  end

  // ---------------- monitor on the falling edge ----------------
  bit meas_on = 0, seen_hi_fall = 0, seen_lo_fall = 0;
  int exp_gap = 0;
  int hi_fall_at = 0, lo_fall_at = 0;
  bit p_hi = 0, p_lo = 0;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_on && !done) begin
      check(m_dis ? "R2 upper" : (m_role ? "R4 upper" : "R6 upper"), gate_up, m_ghi);
      check(m_dis ? "R2 lower" : (m_role ? "R5 lower" : "R6 lower"), gate_dn, m_glo);
      check("R3 overlap", gate_up & gate_dn, 0);
      if (meas_on) begin
        if (p_hi && !gate_up) begin hi_fall_at = cyc; seen_hi_fall = 1; end
        if (p_lo && !gate_dn) begin lo_fall_at = cyc; seen_lo_fall = 1; end
        if (!p_lo && gate_dn && seen_hi_fall) check("R10 gap up->dn", cyc - hi_fall_at, exp_gap);
        if (!p_hi && gate_up && seen_lo_fall) check("R10 gap dn->up", cyc - lo_fall_at, exp_gap);
      end
      p_hi = gate_up; p_lo = gate_dn;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit u, input bit d, input int n);
    @(negedge clk);
    ideal_up = u; ideal_dn = d;
    if (n > 1) repeat (n - 1) @(negedge clk);
  endtask

  task automatic setup(input int d, input bit dir);
    @(negedge clk);
    en = 0; dead_cyc = DW'(d); cur_dir = dir;
    idle(4);
    en = 1;
  endtask

  task automatic start_meas(input int g);
    meas_on = 1; seen_hi_fall = 0; seen_lo_fall = 0; exp_gap = g;
  endtask

  task automatic finish_run;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int dmax;
    void'($urandom(32'd5511));
    // R1: reset state
    idle(3);
    check("R1 upper in reset", gate_up, 0);
    check("R1 lower in reset", gate_dn, 0);
    rst = 0;
    idle(1);
    check("R1 upper after reset", gate_up, 0);
    check("R1 lower after reset", gate_dn, 0);
    chk_on = 1;

    // R4 R5 R10: positive current, D=3
    setup(3, 1);
    start_meas(3);
    drive(0, 1, 12);
    repeat (4) begin drive(1, 0, 15); drive(0, 1, 15); end
    meas_on = 0;

    // R6 R10: negative current, D=1
    setup(1, 0);
    start_meas(1);
    drive(0, 1, 6);
    repeat (4) begin drive(1, 0, 6); drive(0, 1, 6); end
    meas_on = 0;

    // R7: polarity flip mid-pulse, D=4
    setup(4, 1);
    drive(0, 1, 20);
    drive(1, 0, 20);
    cur_dir = 0;
    idle(10);
    check("R7 upper holds role mid-pulse", gate_up, 1);
    check("R7 lower off mid-pulse", gate_dn, 0);
    drive(0, 1, 40);
    drive(1, 0, 7);
    check("R7 new role adopted at rise (upper lags)", gate_up, 0);
    idle(20);
    drive(0, 1, 20);

    // R8: dead change while enabled ignored; zero treated as one
    setup(5, 1);
    start_meas(5);
    drive(0, 1, 20);
    dead_cyc = 8'd2;
    repeat (3) begin drive(1, 0, 20); drive(0, 1, 20); end
    meas_on = 0;
    setup(0, 1);
    start_meas(1);
    drive(0, 1, 8);
    repeat (3) begin drive(1, 0, 8); drive(0, 1, 8); end
    meas_on = 0;

    // R10 boundary: D=255
    dmax = MAXD;
    setup(dmax, 0);
    start_meas(dmax);
    drive(0, 1, 2 * dmax + 10);
    drive(1, 0, 2 * dmax + 10);
    drive(0, 1, 2 * dmax + 10);
    drive(1, 0, 2 * dmax + 10);
    meas_on = 0;

    // R9: ambiguous samples count as off
    setup(3, 1);
    drive(1, 0, 20);
    drive(1, 1, 12);
    check("R9 upper off on both-high", gate_up, 0);
    check("R9 lower off on both-high", gate_dn, 0);
    drive(0, 0, 12);
    check("R9 upper off on both-low", gate_up, 0);
    check("R9 lower off on both-low", gate_dn, 0);

    // R2: disable mid-stream
    drive(1, 0, 10);
    en = 0;
    idle(2);
    check("R2 upper forced off", gate_up, 0);
    check("R2 lower forced off", gate_dn, 0);
    en = 1;

    // random mix
    repeat (300) begin
      int w;
      if ($urandom_range(0, 19) == 0) setup($urandom_range(0, 12), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) cur_dir = ~cur_dir;
      if ($urandom_range(0, 29) == 0) dead_cyc = DW'($urandom_range(0, 20));
      w = $urandom_range(1, 30);
      case ($urandom_range(0, 9))
        0:       drive(1, 1, w);
        1:       drive(0, 0, w);
        2, 3, 4: drive(1, 0, w);
        default: drive(0, 1, w);
      endcase
    end
    idle(5);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule